// File: doc/BRIEF.md
# Timer interrupt router and status

This block collects the fire pulses of a bank of timer channels and turns them into a vector of interrupt request lines and a status word. Each channel is set up by its own inputs: an enable, a trigger type and a route field. A level-type channel sets a sticky status bit and holds its line high until software clears the bit. An edge-type channel raises its line for one cycle and leaves its status bit clear. A global enable gates every channel. The counting that produces the fire pulses is done elsewhere.

A legacy substitution mode moves channels 0 and 1 off their route fields and onto lines 0 and 8. Line 8 normally carries an external real-time-clock interrupt, passed through after one register stage. While the mode is on, that input is blocked and an output tells the legacy timer to stand down. When the mode is switched off, line 8 returns to the most recently sampled clock-interrupt level. A line that has more than one source is the OR of all its sources.

Top module: `tmr_irq_router`

## Requirements
- R1: While rst_ni is low, irq_o, status_o and legacy_off_o are all zero.
- R2: A fire on an active level-type channel t (lvl_i[t]=1, tmr_en_i[t]=1, glb_en_i=1) sets status_o[t] at the next clock edge. The line that channel is routed to stays high for as long as that bit stays set.
- R3: A fire on an active edge-type channel t (lvl_i[t]=0) clears status_o[t] at the next edge and raises the channel's line for exactly one cycle.
- R4: If tmr_en_i[t] or glb_en_i is 0 at an edge, status_o[t] is 0 after that edge. A fire in that cycle produces neither a status bit nor a line. Dropping an enable therefore lowers the line held by a level-type channel.
- R5: A cycle with clr_we_i=1 clears each status bit whose clr_data_i bit is 1. Status bits whose clr_data_i bit is 0 keep their value. A fire in the same cycle takes priority over the clear.
- R6: While legacy_off_o is 0, channel t drives line route_i[t*ROUTE_W +: ROUTE_W], where ROUTE_W=$clog2(NUM_LINES).
- R7: While legacy_off_o is 1, channel 0 drives line 0 and channel 1 drives line 8. All other channels keep their route fields.
- R8: rtc_irq_i is registered once. While legacy_off_o is 0 it contributes to line 8. While legacy_off_o is 1 it is blocked.
- R9: legacy_off_o equals legacy_i delayed by one clock. When it falls, line 8 takes the last sampled rtc_irq_i level without waiting for a new edge on that input.
- R10: Each line is the OR of the RTC contribution (line 8 only) and every channel routed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| glb_en_i | input | 1 | Global enable for all channels |
| fire_i | input | NUM_TMR | Per-channel fire pulse |
| tmr_en_i | input | NUM_TMR | Per-channel enable |
| lvl_i | input | NUM_TMR | Trigger type, 1 = level, 0 = edge |
| route_i | input | NUM_TMR*ROUTE_W | Packed route fields, channel t at bits t*ROUTE_W upward |
| legacy_i | input | 1 | Legacy substitution mode request |
| rtc_irq_i | input | 1 | External real-time-clock interrupt level |
| clr_we_i | input | 1 | Status clear strobe |
| clr_data_i | input | NUM_TMR | Write-1-to-clear mask for the status bits |
| irq_o | output | NUM_LINES | Interrupt request lines |
| status_o | output | NUM_TMR | Sticky status bits of the level-type channels |
| legacy_off_o | output | 1 | Legacy timer disable |

## Verification
The bench builds the block with NUM_TMR=5 and NUM_LINES=32. With five channels, some channels lie outside the two that legacy mode redirects, so the bench can check that those channels keep their route fields while channels 0 and 1 are moved. The full 32-line vector makes every 5-bit route value a real line. Random routes are drawn mostly from a small set that includes 0 and 8. This makes channels collide on the same line and on the RTC line, in both modes.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  // fixed lines used by legacy substitution and the clock-interrupt passthrough
  localparam int unsigned LEG_T0_LINE = 0;
  localparam int unsigned LEG_T1_LINE = 8;
  localparam int unsigned RTC_LINE    = 8;
  localparam int unsigned MIN_LINES   = 9;
endpackage

// File: rtl/tmr_irq_src.sv
module tmr_irq_src (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic act_i,
  input  logic lvl_i,
  input  logic clr_i,
  output logic status_o,
  output logic line_o
);
  logic status_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= fire_i & act_i & ~lvl_i;
      if (!act_i)      status_q <= 1'b0;
      else if (fire_i) status_q <= lvl_i;   // fire beats clear
      else if (clr_i)  status_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign line_o   = status_q | pulse_q;
endmodule

// File: rtl/tmr_legacy_ctl.sv
module tmr_legacy_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic legacy_i,
  input  logic rtc_irq_i,
  output logic leg_o,
  output logic rtc_line_o
);
  logic leg_q, rtc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_q <= 1'b0;
      rtc_q <= 1'b0;
    end else begin
      leg_q <= legacy_i;
      rtc_q <= rtc_irq_i;
    end
  end

  assign leg_o      = leg_q;
  assign rtc_line_o = rtc_q & ~leg_q;
endmodule

// File: rtl/tmr_irq_mux.sv
module tmr_irq_mux
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_TMR   = 3,
  parameter int unsigned NUM_LINES = 32,
  localparam int unsigned ROUTE_W  = $clog2(NUM_LINES)
) (
  input  logic [NUM_TMR-1:0]         src_i,
  input  logic [NUM_TMR*ROUTE_W-1:0] route_i,
  input  logic                       leg_i,
  input  logic                       rtc_line_i,
  output logic [NUM_LINES-1:0]       irq_o
);
  logic [NUM_TMR-1:0][ROUTE_W-1:0] eff_route;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_route
    if (t == 0) begin : g_t0
      assign eff_route[t] = leg_i ? ROUTE_W'(LEG_T0_LINE) : route_i[t*ROUTE_W +: ROUTE_W];
    end else if (t == 1) begin : g_t1
      assign eff_route[t] = leg_i ? ROUTE_W'(LEG_T1_LINE) : route_i[t*ROUTE_W +: ROUTE_W];
    end else begin : g_tn
      assign eff_route[t] = route_i[t*ROUTE_W +: ROUTE_W];
    end
  end

  always_comb begin
    irq_o = '0;
    irq_o[RTC_LINE] = rtc_line_i;
    for (int t = 0; t < NUM_TMR; t++) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if (eff_route[t] == ROUTE_W'(l)) irq_o[l] = irq_o[l] | src_i[t];
      end
    end
  end
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_TMR   = 3,
  parameter int unsigned NUM_LINES = 32,
  localparam int unsigned ROUTE_W  = $clog2(NUM_LINES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       glb_en_i,
  input  logic [NUM_TMR-1:0]         fire_i,
  input  logic [NUM_TMR-1:0]         tmr_en_i,
  input  logic [NUM_TMR-1:0]         lvl_i,
  input  logic [NUM_TMR*ROUTE_W-1:0] route_i,
  input  logic                       legacy_i,
  input  logic                       rtc_irq_i,
  input  logic                       clr_we_i,
  input  logic [NUM_TMR-1:0]         clr_data_i,
  output logic [NUM_LINES-1:0]       irq_o,
  output logic [NUM_TMR-1:0]         status_o,
  output logic                       legacy_off_o
);
  logic [NUM_TMR-1:0] src_line;
  logic               leg, rtc_line;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_src
    tmr_irq_src u_src (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (fire_i[t]),
      .act_i   (tmr_en_i[t] & glb_en_i),
      .lvl_i   (lvl_i[t]),
      .clr_i   (clr_we_i & clr_data_i[t]),
      .status_o(status_o[t]),
      .line_o  (src_line[t])
    );
  end

  tmr_legacy_ctl u_leg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .legacy_i  (legacy_i),
    .rtc_irq_i (rtc_irq_i),
    .leg_o     (leg),
    .rtc_line_o(rtc_line)
  );

  tmr_irq_mux #(.NUM_TMR(NUM_TMR), .NUM_LINES(NUM_LINES)) u_mux (
    .src_i     (src_line),
    .route_i   (route_i),
    .leg_i     (leg),
    .rtc_line_i(rtc_line),
    .irq_o     (irq_o)
  );

  assign legacy_off_o = leg;
endmodule

// File: rtl/tmr_irq_router_chk.sv
module tmr_irq_router_chk
  import tmr_irq_pkg::*;
#(
  parameter int unsigned NUM_TMR   = 3,
  parameter int unsigned NUM_LINES = 32,
  localparam int unsigned ROUTE_W  = $clog2(NUM_LINES)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       glb_en_i,
  input logic [NUM_TMR-1:0]         fire_i,
  input logic [NUM_TMR-1:0]         tmr_en_i,
  input logic [NUM_TMR-1:0]         lvl_i,
  input logic [NUM_TMR*ROUTE_W-1:0] route_i,
  input logic                       legacy_i,
  input logic                       rtc_irq_i,
  input logic                       clr_we_i,
  input logic [NUM_TMR-1:0]         clr_data_i,
  input logic [NUM_LINES-1:0]       irq_o,
  input logic [NUM_TMR-1:0]         status_o,
  input logic                       legacy_off_o
);
  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (irq_o == '0 && status_o == '0 && !legacy_off_o);
    end
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    // R2
    lvl_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i[t] && tmr_en_i[t] && glb_en_i && lvl_i[t] |=> status_o[t]);
    // R3
    edge_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i[t] && tmr_en_i[t] && glb_en_i && !lvl_i[t] |=> !status_o[t]);
    // R4
    off_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(tmr_en_i[t] && glb_en_i) |=> !status_o[t]);
    // R5
    w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_we_i && clr_data_i[t] && !fire_i[t] |=> !status_o[t]);
    // R5
    w0_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[t] && tmr_en_i[t] && glb_en_i && !fire_i[t] && !(clr_we_i && clr_data_i[t])
      |=> status_o[t]);
  end

  // R9
  leg_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_i |=> legacy_off_o);
  // R9
  leg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legacy_i |=> !legacy_off_o);
  // R8
  rtc_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legacy_i && rtc_irq_i |=> irq_o[RTC_LINE]);
  // R7
  leg_t0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_off_o && status_o[0] |-> irq_o[LEG_T0_LINE]);
  // R7
  leg_t1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_off_o && status_o[1] |-> irq_o[LEG_T1_LINE]);
endmodule

bind tmr_irq_router tmr_irq_router_chk #(.NUM_TMR(NUM_TMR), .NUM_LINES(NUM_LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .glb_en_i(glb_en_i), .fire_i(fire_i),
  .tmr_en_i(tmr_en_i), .lvl_i(lvl_i), .route_i(route_i), .legacy_i(legacy_i),
  .rtc_irq_i(rtc_irq_i), .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
  .irq_o(irq_o), .status_o(status_o), .legacy_off_o(legacy_off_o)
);

// File: tb/tmr_irq_router_tb_top.sv
module tmr_irq_router_tb_top;
  localparam int NT = 5;
  localparam int NL = 32;
  localparam int RW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en;
  logic [NT-1:0] fire, tmr_en, lvl, clr_data;
  logic [RW-1:0] route [NT];
  logic [NT*RW-1:0] route_flat;
  logic legacy, rtc, clr_we;
  logic [NL-1:0] irq_o;
  logic [NT-1:0] status_o;
  logic legacy_off_o;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  logic [NT-1:0] m_stat, m_pulse;
  logic m_leg, m_rtc;

  always #5 clk = ~clk;

  always_comb begin
    for (int t = 0; t < NT; t++) route_flat[t*RW +: RW] = route[t];
  end

  tmr_irq_router #(.NUM_TMR(NT), .NUM_LINES(NL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .fire_i(fire),
    .tmr_en_i(tmr_en), .lvl_i(lvl), .route_i(route_flat), .legacy_i(legacy),
    .rtc_irq_i(rtc), .clr_we_i(clr_we), .clr_data_i(clr_data),
    .irq_o(irq_o), .status_o(status_o), .legacy_off_o(legacy_off_o)
  );

  function automatic logic [NL-1:0] exp_irq();
    logic [NL-1:0] e = '0;
    for (int t = 0; t < NT; t++) begin
      int l = int'(route[t]);
      if (m_leg && t == 0) l = 0;
      if (m_leg && t == 1) l = 8;
      if (m_stat[t] | m_pulse[t]) e[l] = 1'b1;
    end
    if (!m_leg && m_rtc) e[8] = 1'b1;
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    for (int t = 0; t < NT; t++) begin
      logic act = tmr_en[t] & glb_en;
      if (!act) m_stat[t] = 1'b0;
      else if (fire[t]) m_stat[t] = lvl[t];
      else if (clr_we && clr_data[t]) m_stat[t] = 1'b0;
      m_pulse[t] = fire[t] & act & ~lvl[t];
    end
    m_leg = legacy;
    m_rtc = rtc;
    #1;
    chk(tag, "irq", irq_o, exp_irq());
    chk(tag, "status", 32'(status_o), 32'(m_stat));
    chk(tag, "legacy_off", 32'(legacy_off_o), 32'(m_leg));
  endtask

  task automatic quiet();
    @(negedge clk);
    fire = '0; clr_we = 1'b0; clr_data = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    glb_en = 1'b0; fire = '0; tmr_en = '0; lvl = '0; clr_data = '0;
    legacy = 1'b1; rtc = 1'b1; clr_we = 1'b0;
    for (int t = 0; t < NT; t++) route[t] = RW'(t + 1);
    m_stat = '0; m_pulse = '0; m_leg = 1'b0; m_rtc = 1'b0;
    glb_en = 1'b1; tmr_en = '1; lvl = '1; fire = '1;
    repeat (3) @(posedge clk);
    #1;
    // R1: inputs active but reset held
    chk("R1", "irq", irq_o, '0);
    chk("R1", "status", 32'(status_o), 0);
    chk("R1", "legacy_off", 32'(legacy_off_o), 0);
    @(negedge clk);
    fire = '0; legacy = 1'b0; rtc = 1'b0; lvl = '0;
    rst_n = 1'b1;
    cyc("R1");

    // R2: level fire on channel 2, route 5
    quiet(); lvl[2] = 1'b1; route[2] = 5; fire[2] = 1'b1;
    cyc("R2");
    chk("R2", "irq", irq_o, 32'h20);
    chk("R2", "status", 32'(status_o), 32'h4);
    quiet(); cyc("R2"); cyc("R2");
    chk("R2", "irq held", irq_o, 32'h20);

    // R5: write 0 no effect, then write 1 clears
    quiet(); clr_we = 1'b1; clr_data = 5'b11011;
    cyc("R5");
    chk("R5", "status kept", 32'(status_o), 32'h4);
    quiet(); clr_we = 1'b1; clr_data[2] = 1'b1;
    cyc("R5");
    chk("R5", "irq cleared", irq_o, 32'h0);
    // R5: fire with clear in same cycle keeps bit set
    quiet(); clr_we = 1'b1; clr_data[2] = 1'b1; fire[2] = 1'b1;
    cyc("R5");
    chk("R5", "fire wins", 32'(status_o), 32'h4);
    quiet(); clr_we = 1'b1; clr_data = '1; cyc("R5");

    // R3: edge fire on channel 3, route 12
    quiet(); lvl[3] = 1'b0; route[3] = 12; fire[3] = 1'b1;
    cyc("R3");
    chk("R3", "pulse", irq_o, 32'h1000);
    chk("R3", "status", 32'(status_o), 0);
    quiet(); cyc("R3");
    chk("R3", "pulse ends", irq_o, 32'h0);

    // R4: fire with global enable off, then enable drop on a held line
    quiet(); glb_en = 1'b0; fire[2] = 1'b1;
    cyc("R4");
    chk("R4", "gated", irq_o, 32'h0);
    quiet(); glb_en = 1'b1; fire[2] = 1'b1; cyc("R4");
    quiet(); tmr_en[2] = 1'b0;
    cyc("R4");
    chk("R4", "enable dropped", irq_o, 32'h0);
    chk("R4", "status", 32'(status_o), 0);
    quiet(); tmr_en = '1;

    // R8: passthrough, then blocked
    quiet(); rtc = 1'b1; cyc("R8");
    chk("R8", "rtc through", irq_o, 32'h100);
    quiet(); legacy = 1'b1; cyc("R9");
    chk("R8", "rtc blocked", irq_o, 32'h0);
    chk("R9", "legacy_off", 32'(legacy_off_o), 1);

    // R7: channels 0 and 1 redirected, channel 2 keeps route
    quiet(); lvl[1:0] = 2'b11; route[0] = 20; route[1] = 21; route[2] = 3; fire[2:0] = 3'b111;
    cyc("R7");
    chk("R7", "redirect", irq_o, 32'h109);
    quiet(); clr_we = 1'b1; clr_data = '1; cyc("R7");

    // R9: release restores sampled rtc level on line 8
    quiet(); legacy = 1'b0; cyc("R9");
    chk("R9", "rtc restored", irq_o, 32'h100);
    chk("R9", "legacy_off", 32'(legacy_off_o), 0);
    quiet(); rtc = 1'b0; cyc("R9");

    // R10 / R6: two channels share line 7; clear one, other holds it
    quiet(); lvl[4:3] = 2'b11; route[3] = 7; route[4] = 7; fire[4:3] = 2'b11;
    cyc("R10");
    chk("R10", "shared", irq_o, 32'h80);
    quiet(); clr_we = 1'b1; clr_data[3] = 1'b1; cyc("R10");
    chk("R10", "one left", irq_o, 32'h80);
    quiet(); clr_we = 1'b1; clr_data = '1; cyc("R6");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int t = 0; t < NT; t++) begin
        int pick = $urandom_range(0, 4);
        fire[t] = ($urandom_range(0, 9) < 3);
        tmr_en[t] = ($urandom_range(0, 9) != 0);
        if ($urandom_range(0, 15) == 0) lvl[t] = $urandom_range(0, 1) != 0;
        if ($urandom_range(0, 31) == 0)
          route[t] = (pick == 0) ? RW'(0) : (pick == 1) ? RW'(8) : (pick == 2) ? RW'(3) :
                     (pick == 3) ? RW'(31) : RW'($urandom_range(0, NL - 1));
      end
      glb_en = ($urandom_range(0, 19) != 0);
      clr_we = ($urandom_range(0, 4) == 0);
      clr_data = NT'($urandom());
      if ($urandom_range(0, 39) == 0) legacy = ~legacy;
      if ($urandom_range(0, 7) == 0) rtc = ~rtc;
      cyc((i % 2 == 0) ? "R6" : "R10");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule